// File: doc/BRIEF.md
# Abort-Tracking Gating Entry Controller

This block is one per-processor entry of a directory's abort table. It keeps the abort history of a single victim processor and drives that processor's clock-stop and clock-on signals. When an invalidation from a committing processor aborts the victim, the entry logs the aborter, counts the abort, gates the victim and starts a down-counting gating timer. The entry then asks the aborter for the transaction it is running and stores the reply.

When the timer runs out, the entry raises a one-cycle expiry strobe and holds the timer at zero. It then waits for an external ungate checker. A "renew" verdict extends the gating with a fresh period and keeps the victim off. A "wake" verdict turns the victim's clock back on.

Two further events act on the entry. A load or store from a victim still marked off means another directory has already woken it, so the off state is dropped quietly. A commit by the victim clears both counts. The gating period value and the ungate decision are computed outside the block.

The request and reply for the aborter's transaction id use valid/ready handshakes.
- The request holds its valid and its processor id stable until ready is seen.
- The reply side raises ready only while a reply is awaited.
- A reply offered at any other time is not taken.

All other pins are plain single-cycle or level control and status.

Top module: `abort_gate_entry`

## Requirements
- R1: After reset the entry reads off = 0, abort count = 0, renew count = 0, timer = 0. It reads stop-clock = 0, clock-on = 0, expired = 0, request valid = 0 and reply ready = 0.
- R2: An abort event causes all of the following on the next cycle:
  - the aborter id field holds the event's processor id;
  - the abort count is one higher and the renew count is 0;
  - the transaction id field is 0 and off = 1;
  - stop-clock is high for exactly one cycle.

  An abort takes precedence over a commit or a verdict in the same cycle.
- R3: The 8-bit abort count saturates at 255; further aborts leave it at 255.
- R4: Each abort, renew or count-clearing commit loads the timer with the supplied period, or with 1 when the period is 0. While nonzero, the timer drops by one per cycle. When it reaches 0 with off = 1, expired is high for that one cycle. The timer then stays 0 with a check pending and expired does not fire again.
- R5: The cycle after an abort, request valid is high with the aborter id, and it holds until request ready is seen. Reply ready is then high until a reply is valid. The reply's 64-bit id is stored in the transaction id field. A reply offered while reply ready is low is ignored.
- R6: With a check pending, a renew verdict (check valid with renew = 1) causes three things on the next cycle: the renew count increments, the timer holds the period, and off stays 1 with no clock-on.
- R7: With a check pending, a wake verdict (check valid with renew = 0) raises clock-on for exactly one cycle and clears off.
- R8: A verdict arriving while no check is pending has no effect on counts, off or clock-on.
- R9: An access from the victim while off = 1 clears off on the next cycle without a clock-on pulse and discards any pending check. An access while off = 0 has no effect.
- R10: A commit clears both counts and leaves off unchanged. If either count was nonzero, the timer is reloaded with the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Directory clock |
| rst_n | input | 1 | Active-low reset |
| abort_valid_i | input | 1 | Invalidation has aborted the victim this cycle |
| abort_pid_i | input | PID_W | Committing (aborter) processor id |
| commit_i | input | 1 | Victim committed its transaction |
| access_i | input | 1 | Load or store arrived from the victim |
| period_i | input | TMR_W | Gating period to load into the timer |
| chk_valid_i | input | 1 | Ungate checker verdict valid |
| chk_renew_i | input | 1 | Verdict: 1 renew gating, 0 wake |
| txreq_valid_o | output | 1 | Transaction-info request valid |
| txreq_pid_o | output | PID_W | Processor the request is addressed to |
| txreq_ready_i | input | 1 | Request accepted |
| txrsp_valid_i | input | 1 | Transaction id reply valid |
| txrsp_id_i | input | TXID_W | Reply: id of the aborter's transaction |
| txrsp_ready_o | output | 1 | Entry awaits a reply |
| stop_clk_o | output | 1 | One-cycle stop-clock command to victim |
| clk_on_o | output | 1 | One-cycle clock-on command to victim |
| expired_o | output | 1 | One-cycle gating-timer expiry strobe |
| off_o | output | 1 | Victim marked gated |
| aborter_pid_o | output | PID_W | Logged aborter processor id |
| aborter_txid_o | output | TXID_W | Logged aborter transaction id |
| abort_cnt_o | output | CNT_W | Abort count |
| renew_cnt_o | output | RNW_W | Renew count |
| timer_o | output | TMR_W | Gating timer value |

## Verification
Every result is registered, so each is due on the clock edge that samples its stimulus. The bench drives inputs at a falling edge, lets one rising edge pass, and reads the outputs at the next falling edge. Each check sits exactly one cycle after its event. The exceptions are the timer expiry, due exactly period cycles after the load, and the reply capture, due one cycle after the reply handshake. The bench steps the clock by that exact count and checks the cycle before as well, so an early or late strobe is caught.

// File: rtl/gate_pkg.sv
package gate_pkg;
  typedef enum logic [1:0] {
    FETCH_IDLE = 2'd0,
    FETCH_REQ  = 2'd1,
    FETCH_WAIT = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/gate_counters.sv
module gate_counters #(
  parameter int CNT_W = 8,
  parameter int RNW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort_ev,
  input  logic             renew_ev,
  input  logic             commit_ev,
  output logic [CNT_W-1:0] abort_cnt,
  output logic [RNW_W-1:0] renew_cnt,
  output logic             reload
);
  localparam logic [CNT_W-1:0] ACNT_MAX = {CNT_W{1'b1}};
  localparam logic [RNW_W-1:0] RCNT_MAX = {RNW_W{1'b1}};

  logic counts_nz;
  assign counts_nz = (abort_cnt != '0) || (renew_cnt != '0);
  assign reload    = abort_ev | renew_ev | (commit_ev & counts_nz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_cnt <= '0;
      renew_cnt <= '0;
    end else if (abort_ev) begin
      if (abort_cnt != ACNT_MAX) abort_cnt <= abort_cnt + 1'b1;
      renew_cnt <= '0;
    end else if (renew_ev) begin
      if (renew_cnt != RCNT_MAX) renew_cnt <= renew_cnt + 1'b1;
    end else if (commit_ev) begin
      abort_cnt <= '0;
      renew_cnt <= '0;
    end
  end

  AST_ABORT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_ev && abort_cnt == ACNT_MAX) |=> abort_cnt == ACNT_MAX); // R3
  AST_ABORT_RENEW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (renew_cnt == '0) && (abort_cnt != '0)); // R2
  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ev && !abort_ev && !renew_ev) |=> (abort_cnt == '0) && (renew_cnt == '0)); // R10
endmodule

// File: rtl/gate_timer.sv
module gate_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] period,
  input  logic             armed,
  input  logic             drop,
  output logic [TMR_W-1:0] tmr,
  output logic             pend,
  output logic             expired
);
  localparam logic [TMR_W-1:0] T_ONE = {{(TMR_W-1){1'b0}}, 1'b1};

  logic [TMR_W-1:0] ld_val;
  assign ld_val = (period == '0) ? T_ONE : period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr     <= '0;
      pend    <= 1'b0;
      expired <= 1'b0;
    end else if (load) begin
      tmr     <= ld_val;
      pend    <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (tmr != '0) begin
        tmr <= tmr - T_ONE;
        if (tmr == T_ONE && armed) begin
          pend    <= 1'b1;
          expired <= 1'b1;
        end
      end
      if (drop) pend <= 1'b0;
    end
  end

  AST_EXP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !expired); // R4
  AST_EXP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> (tmr == '0) && pend); // R4
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !load) |=> tmr == '0); // R4
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr != '0 && !load) |=> tmr == $past(tmr) - T_ONE); // R4
endmodule

// File: rtl/gate_txfetch.sv
module gate_txfetch
  import gate_pkg::*;
#(
  parameter int PID_W  = 4,
  parameter int TXID_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PID_W-1:0]  start_pid,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [TXID_W-1:0] rsp_id,
  output logic              req_valid,
  output logic [PID_W-1:0]  req_pid,
  output logic              rsp_ready,
  output logic [TXID_W-1:0] txid
);
  fetch_st_e st;

  assign req_valid = (st == FETCH_REQ);
  assign rsp_ready = (st == FETCH_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= FETCH_IDLE;
      req_pid <= '0;
      txid    <= '0;
    end else if (start) begin
      st      <= FETCH_REQ;
      req_pid <= start_pid;
      txid    <= '0;
    end else begin
      case (st)
        FETCH_REQ:  if (req_ready) st <= FETCH_WAIT;
        FETCH_WAIT: if (rsp_valid) begin
          txid <= rsp_id;
          st   <= FETCH_IDLE;
        end
        default:    st <= FETCH_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !start) |=> req_valid && $stable(req_pid)); // R5
  AST_TXID_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(rsp_valid && rsp_ready)) |=> $stable(txid)); // R5
  AST_RSP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && rsp_valid && rsp_ready) |=> (txid == $past(rsp_id)) && !rsp_ready); // R5
endmodule

// File: rtl/abort_gate_entry.sv
module abort_gate_entry #(
  parameter int PID_W  = 4,
  parameter int TXID_W = 64,
  parameter int CNT_W  = 8,
  parameter int RNW_W  = 8,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_valid_i,
  input  logic [PID_W-1:0]  abort_pid_i,
  input  logic              commit_i,
  input  logic              access_i,
  input  logic [TMR_W-1:0]  period_i,
  input  logic              chk_valid_i,
  input  logic              chk_renew_i,
  output logic              txreq_valid_o,
  output logic [PID_W-1:0]  txreq_pid_o,
  input  logic              txreq_ready_i,
  input  logic              txrsp_valid_i,
  input  logic [TXID_W-1:0] txrsp_id_i,
  output logic              txrsp_ready_o,
  output logic              stop_clk_o,
  output logic              clk_on_o,
  output logic              expired_o,
  output logic              off_o,
  output logic [PID_W-1:0]  aborter_pid_o,
  output logic [TXID_W-1:0] aborter_txid_o,
  output logic [CNT_W-1:0]  abort_cnt_o,
  output logic [RNW_W-1:0]  renew_cnt_o,
  output logic [TMR_W-1:0]  timer_o
);
  logic off_q, stop_q, on_q;
  logic [PID_W-1:0] apid_q;
  logic pend, reload;
  logic verdict, renew_ev, wake_chk, wake_acc, commit_ev, armed, drop;

  // Priority: abort, then verdict, then access wake and commit.
  assign verdict   = chk_valid_i & pend & ~abort_valid_i;
  assign renew_ev  = verdict & chk_renew_i;
  assign wake_chk  = verdict & ~chk_renew_i;
  assign wake_acc  = access_i & off_q & ~abort_valid_i & ~verdict;
  assign commit_ev = commit_i & ~abort_valid_i & ~renew_ev;
  assign armed     = off_q & ~wake_acc & ~wake_chk;
  assign drop      = wake_chk | wake_acc;

  gate_counters #(.CNT_W(CNT_W), .RNW_W(RNW_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort_ev  (abort_valid_i),
    .renew_ev  (renew_ev),
    .commit_ev (commit_ev),
    .abort_cnt (abort_cnt_o),
    .renew_cnt (renew_cnt_o),
    .reload    (reload)
  );

  gate_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (reload),
    .period  (period_i),
    .armed   (armed),
    .drop    (drop),
    .tmr     (timer_o),
    .pend    (pend),
    .expired (expired_o)
  );

  gate_txfetch #(.PID_W(PID_W), .TXID_W(TXID_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (abort_valid_i),
    .start_pid (abort_pid_i),
    .req_ready (txreq_ready_i),
    .rsp_valid (txrsp_valid_i),
    .rsp_id    (txrsp_id_i),
    .req_valid (txreq_valid_o),
    .req_pid   (txreq_pid_o),
    .rsp_ready (txrsp_ready_o),
    .txid      (aborter_txid_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= 1'b0;
      stop_q <= 1'b0;
      on_q   <= 1'b0;
      apid_q <= '0;
    end else begin
      stop_q <= abort_valid_i;
      on_q   <= wake_chk;
      if (abort_valid_i) begin
        off_q  <= 1'b1;
        apid_q <= abort_pid_i;
      end else if (wake_chk || wake_acc) begin
        off_q <= 1'b0;
      end
    end
  end

  assign off_o         = off_q;
  assign stop_clk_o    = stop_q;
  assign clk_on_o      = on_q;
  assign aborter_pid_o = apid_q;

  AST_STOP_SETS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    stop_clk_o |-> off_o); // R2
  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_clk_o && !$past(abort_valid_i)) |-> 1'b0); // R2
  AST_ON_CLEARS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    clk_on_o |-> !off_o && !stop_clk_o); // R7
  AST_RENEW_KEEPS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    renew_ev |=> off_o && !clk_on_o); // R6
  AST_ACCESS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (access_i && off_o && !abort_valid_i && !chk_valid_i) |=> !off_o && !clk_on_o); // R9
  AST_IGNORE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && !pend && !abort_valid_i && !access_i && !commit_i)
      |=> $stable(off_o) && $stable(renew_cnt_o) && !clk_on_o); // R8
  AST_COMMIT_OFF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !abort_valid_i && !chk_valid_i && !access_i) |=> off_o == $past(off_o)); // R10
endmodule

// File: tb/abort_gate_entry_tb_top.sv
module abort_gate_entry_tb_top;
  localparam int PID_W = 4, TXID_W = 64, CNT_W = 8, RNW_W = 8, TMR_W = 16;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_ABORT = 2'd1, OP_COMMIT = 2'd2, OP_ACCESS = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [3:0] pid;
    logic       off;
    logic [7:0] acnt;
    logic [7:0] rcnt;
    logic [3:0] apid;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{OP_ABORT,  4'd3, 1'b1, 8'd1, 8'd0, 4'd3},
    '{OP_ABORT,  4'd5, 1'b1, 8'd2, 8'd0, 4'd5},
    '{OP_ACCESS, 4'd0, 1'b0, 8'd2, 8'd0, 4'd5},
    '{OP_ACCESS, 4'd0, 1'b0, 8'd2, 8'd0, 4'd5},
    '{OP_COMMIT, 4'd0, 1'b0, 8'd0, 8'd0, 4'd5},
    '{OP_ABORT,  4'd2, 1'b1, 8'd1, 8'd0, 4'd2},
    '{OP_COMMIT, 4'd0, 1'b1, 8'd0, 8'd0, 4'd2},
    '{OP_ABORT,  4'd7, 1'b1, 8'd1, 8'd0, 4'd7},
    '{OP_IDLE,   4'd0, 1'b1, 8'd1, 8'd0, 4'd7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic abort_valid = 0, commit = 0, access = 0, chk_valid = 0, chk_renew = 0;
  logic [PID_W-1:0] abort_pid = '0;
  logic [TMR_W-1:0] period = '0;
  logic txreq_ready = 0, txrsp_valid = 0;
  logic [TXID_W-1:0] txrsp_id = '0;
  logic txreq_valid, txrsp_ready, stop_clk, clk_on, expired, off;
  logic [PID_W-1:0] txreq_pid, apid;
  logic [TXID_W-1:0] atxid;
  logic [CNT_W-1:0] acnt;
  logic [RNW_W-1:0] rcnt;
  logic [TMR_W-1:0] timer;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  abort_gate_entry #(.PID_W(PID_W), .TXID_W(TXID_W), .CNT_W(CNT_W), .RNW_W(RNW_W), .TMR_W(TMR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .abort_valid_i(abort_valid), .abort_pid_i(abort_pid),
    .commit_i(commit), .access_i(access), .period_i(period),
    .chk_valid_i(chk_valid), .chk_renew_i(chk_renew),
    .txreq_valid_o(txreq_valid), .txreq_pid_o(txreq_pid), .txreq_ready_i(txreq_ready),
    .txrsp_valid_i(txrsp_valid), .txrsp_id_i(txrsp_id), .txrsp_ready_o(txrsp_ready),
    .stop_clk_o(stop_clk), .clk_on_o(clk_on), .expired_o(expired), .off_o(off),
    .aborter_pid_o(apid), .aborter_txid_o(atxid), .abort_cnt_o(acnt),
    .renew_cnt_o(rcnt), .timer_o(timer)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_in();
    abort_valid = 0; commit = 0; access = 0; chk_valid = 0; chk_renew = 0; txrsp_valid = 0;
  endtask

  task automatic do_reset();
    clear_in();
    rst_n = 0;
    step(3);
    rst_n = 1;
    step(1);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1", "off", off, 0);
    chk("R1", "abort_cnt", acnt, 0);
    chk("R1", "renew_cnt", rcnt, 0);
    chk("R1", "timer", timer, 0);
    chk("R1", "strobes", {stop_clk, clk_on, expired}, 0);
    chk("R1", "handshake", {txreq_valid, txrsp_ready}, 0);

    // Vector table: R2 abort logging, R9 access, R10 commit
    period = 16'd100;
    txreq_ready = 1;
    for (int v = 0; v < NVEC; v++) begin
      case (VEC[v].op)
        OP_ABORT:  begin abort_valid = 1; abort_pid = VEC[v].pid; end
        OP_COMMIT: commit = 1;
        OP_ACCESS: access = 1;
        default:   ;
      endcase
      step(1);
      clear_in();
      chk("R2/R9/R10", "table off", off, VEC[v].off);
      chk("R2/R10", "table abort_cnt", acnt, VEC[v].acnt);
      chk("R2", "table renew_cnt", rcnt, VEC[v].rcnt);
      chk("R2", "table aborter_pid", apid, VEC[v].apid);
      chk("R2", "table stop_clk", stop_clk, (VEC[v].op == OP_ABORT));
    end

    // R4 timer and expiry
    do_reset();
    period = 16'd5; txreq_ready = 1;
    abort_valid = 1; abort_pid = 4'd6;
    step(1); clear_in();
    chk("R4", "timer after load", timer, 5);
    chk("R2", "off after abort", off, 1);
    chk("R2", "txid cleared", atxid, 0);
    step(1);
    chk("R2", "stop_clk one cycle", stop_clk, 0);
    step(3);
    chk("R4", "timer at 1", timer, 1);
    chk("R4", "no early expiry", expired, 0);
    step(1);
    chk("R4", "timer at 0", timer, 0);
    chk("R4", "expired strobe", expired, 1);
    step(1);
    chk("R4", "expired single", expired, 0);
    step(3);
    chk("R4", "held no refire", {expired, timer}, 0);

    // R6 renew
    chk_valid = 1; chk_renew = 1;
    step(1); clear_in();
    chk("R6", "renew_cnt", rcnt, 1);
    chk("R6", "timer reload", timer, 5);
    chk("R6", "off kept, no on", {off, clk_on}, 2'b10);
    step(5);
    chk("R6", "expiry after renew", expired, 1);

    // R7 wake
    chk_valid = 1; chk_renew = 0;
    step(1); clear_in();
    chk("R7", "clk_on", clk_on, 1);
    chk("R7", "off cleared", off, 0);
    step(1);
    chk("R7", "clk_on single", clk_on, 0);

    // R8 verdict with nothing pending
    chk_valid = 1; chk_renew = 1;
    step(1); clear_in();
    chk("R8", "renew_cnt unchanged", rcnt, 1);
    chk("R8", "off/on unchanged", {off, clk_on}, 0);

    // R4 zero period treated as 1
    period = 16'd0;
    abort_valid = 1; abort_pid = 4'd1;
    step(1); clear_in();
    chk("R4", "zero period timer", timer, 1);
    step(1);
    chk("R4", "zero period expiry", expired, 1);

    // R9 access while pending discards the check
    access = 1;
    step(1); clear_in();
    chk("R9", "off cleared by access", off, 0);
    chk("R9", "no clk_on on access", clk_on, 0);
    chk_valid = 1; chk_renew = 0;
    step(1); clear_in();
    chk("R9", "stale verdict ignored", clk_on, 0);

    // R10 commit while off
    period = 16'd5;
    abort_valid = 1; abort_pid = 4'd8;
    step(1); clear_in();
    chk("R2", "abort_cnt third", acnt, 3);
    step(2);
    commit = 1;
    step(1); clear_in();
    chk("R10", "counts cleared", {acnt, rcnt}, 0);
    chk("R10", "off kept", off, 1);
    chk("R10", "timer reloaded", timer, 5);

    // R2 abort beats commit in the same cycle
    abort_valid = 1; commit = 1; abort_pid = 4'd4;
    step(1); clear_in();
    chk("R2", "abort over commit cnt", acnt, 1);
    chk("R2", "abort over commit pid", apid, 4);

    // R3 saturation
    do_reset();
    period = 16'd1000;
    abort_valid = 1; abort_pid = 4'd2;
    step(255);
    chk("R3", "count at 255", acnt, 255);
    step(1); clear_in();
    chk("R3", "saturated", acnt, 255);

    // R5 transaction id fetch handshake
    do_reset();
    txreq_ready = 0;
    abort_valid = 1; abort_pid = 4'd9;
    step(1); clear_in();
    chk("R5", "req valid", txreq_valid, 1);
    chk("R5", "req pid", txreq_pid, 9);
    chk("R5", "rsp ready low", txrsp_ready, 0);
    step(2);
    chk("R5", "req held", {txreq_valid, txreq_pid}, {1'b1, 4'd9});
    txrsp_valid = 1; txrsp_id = 64'h1111_2222_3333_4444;
    step(1); clear_in();
    chk("R5", "early reply ignored", atxid, 0);
    txreq_ready = 1;
    step(1);
    txreq_ready = 0;
    chk("R5", "req done", txreq_valid, 0);
    chk("R5", "rsp ready", txrsp_ready, 1);
    txrsp_valid = 1; txrsp_id = 64'hCAFE_0000_BEEF_0042;
    step(1); clear_in();
    chk("R5", "txid stored", atxid, 64'hCAFE_0000_BEEF_0042);
    chk("R5", "rsp ready dropped", txrsp_ready, 0);

    done = 1;
    report();
    $finish;
  end
endmodule